// File: doc/BRIEF.md
# Multichannel Serial Converter Frame Reader

This block is the host-side controller for a sampling converter that returns up to six channel results on a single serial data line. It generates a free-running serial clock from the system clock and issues a one-period conversion pulse when a start request arrives. It then counts serial clock edges from that pulse and reassembles each 12-bit channel word from the bits it samples. A frame is made of 16-clock slots, one slot for each selected channel.

The serial clock is derived inside the block, so every serial edge lines up with a known system clock edge. The data line is sampled on the system clock edge at which the serial clock falls. The converter changes its output on rising edges, so each bit has half a serial period to settle. Completed words leave on a result strobe with a channel index. The converter cannot pause once a conversion has begun, so the result port has no ready input. A new word arrives at most once every 16 serial periods, and the consumer must take each word in the cycle its strobe is high.

Top module: `adc_frame_reader`

## Requirements
- R1: The serial clock runs continuously from reset. Each high phase and each low phase lasts HALF_CYC system clock cycles.
- R2: The conversion output rises in the same system cycle as a serial clock rising edge and stays high for exactly one serial period (2*HALF_CYC system cycles).
- R3: The start request is sampled only at serial rising edges while no frame is running. A start request raised during a frame has no effect and produces no additional conversion pulse.
- R4: The 3-bit select value is captured at frame start. Codes 0 to 5 give 1 to 6 channels, and codes 6 and 7 give 6 channels. Changing the select value during a frame does not alter that frame.
- R5: Number the serial rising edges from the one at which the conversion pulse rises (edge 0). Bit k (k = 0 is the MSB) of slot s is the value that follows edge 3+16*s+k. It is sampled at the falling edge that comes after that rising edge.
- R6: Slot positions 12 to 15 (two don't-care bits and two idle bits) never reach a result.
- R7: Each word produces a result strobe that is high for exactly one system cycle. It carries the 12-bit word and a channel index, and the index restarts at 0 in every frame.
- R8: A frame of N channels ends at rising edge 16*N. When the start request is held high, the next conversion pulse rises one serial period later, so consecutive pulses are (16*N+1) serial periods apart.
- R9: During reset the conversion output, the serial clock and the result strobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request for a conversion frame, level sampled |
| chan_sel | input | 3 | Channel-count select |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion start pulse |
| sck_o | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | Result strobe, one cycle per word |
| res_chan | output | 3 | Channel index of the result |
| res_data | output | 12 | Captured 12-bit word |

## Verification
The assertions assume that the start request and the select value are synchronous to the system clock. They also assume that the data line is stable at the system edge where the serial clock falls. The bench's converter model changes the data line one nanosecond after each serial rising edge, which is two system cycles before that sampling edge. It drives ones on every don't-care and idle bit, so a capture at the wrong offset corrupts the expected words. Start requests are raised only between system edges and are held until a conversion pulse appears, except in the deliberate mid-frame pulse that tests R3.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int DATA_W     = 12;
  localparam int SLOT_CLKS  = 16;
  localparam int LEAD_EDGES = 3;
  localparam int MAX_CH     = 6;
  localparam int SEL_W      = 3;
  localparam int CH_W       = 3;
  localparam int FRAME_MAX  = SLOT_CLKS * MAX_CH;
  localparam int CNT_W      = $clog2(FRAME_MAX + 1);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  function automatic logic [CH_W:0] chan_count(input logic [SEL_W-1:0] sel);
    if (int'(sel) >= MAX_CH - 1) return (CH_W+1)'(MAX_CH);
    return {1'b0, sel} + (CH_W+1)'(1);
  endfunction
endpackage

// File: rtl/sck_gen.sv
module sck_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck_o,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap     = (div_q == DW'(HALF_CYC - 1));
  assign rise_evt = wrap & ~sck_o;
  assign fall_evt = wrap & sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_o <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  // R1
  sck_edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o != $past(sck_o)) |-> ($past(rise_evt) || $past(fall_evt)));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import adc_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_evt,
  input  logic                 start_req,
  input  logic [SEL_W-1:0]     chan_sel,
  output logic                 conv_o,
  output logic                 busy,
  output logic [CNT_W-1:0]     edge_cnt,
  output logic [CH_W:0]        nch
);
  seq_state_t          state_q;
  logic [CNT_W-1:0]    end_cnt;

  assign end_cnt = CNT_W'(32'(nch) * SLOT_CLKS);
  assign busy    = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      conv_o   <= 1'b0;
      edge_cnt <= '0;
      nch      <= (CH_W+1)'(1);
    end else if (rise_evt) begin
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q  <= ST_RUN;
            conv_o   <= 1'b1;
            edge_cnt <= '0;
            nch      <= chan_count(chan_sel);
          end
        end
        default: begin
          conv_o <= 1'b0;
          if (edge_cnt + CNT_W'(1) == end_cnt) begin
            state_q  <= ST_IDLE;
            edge_cnt <= '0;
          end else begin
            edge_cnt <= edge_cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R2
  conv_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o && rise_evt) |=> !conv_o);
  // R3
  conv_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> ($past(start_req) && $past(rise_evt) && !$past(busy)));
  // R4
  nch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nch >= 1 && int'(nch) <= MAX_CH));
endmodule

// File: rtl/word_capture.sv
module word_capture
  import adc_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_evt,
  input  logic                 busy,
  input  logic [CNT_W-1:0]     edge_cnt,
  input  logic                 sdo_i,
  output logic                 res_valid,
  output logic [CH_W-1:0]      res_chan,
  output logic [DATA_W-1:0]    res_data
);
  logic [CNT_W-1:0]  pos;
  logic [CNT_W-1:0]  bit_in_slot;
  logic [CNT_W-1:0]  slot_idx;
  logic              in_data;
  logic              last_bit;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_nxt;

  assign pos         = edge_cnt - CNT_W'(LEAD_EDGES);
  assign bit_in_slot = pos % CNT_W'(SLOT_CLKS);
  assign slot_idx    = pos / CNT_W'(SLOT_CLKS);
  assign in_data     = busy && (edge_cnt >= CNT_W'(LEAD_EDGES))
                       && (bit_in_slot < CNT_W'(DATA_W));
  assign last_bit    = (bit_in_slot == CNT_W'(DATA_W - 1));
  assign shreg_nxt   = {shreg[DATA_W-2:0], sdo_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (fall_evt && in_data) begin
        shreg <= shreg_nxt;
        if (last_bit) begin
          res_valid <= 1'b1;
          res_data  <= shreg_nxt;
          res_chan  <= CH_W'(slot_idx);
        end
      end
    end
  end

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R7
  chan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_chan) < MAX_CH));
  // R5
  capture_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(fall_evt) && $past(busy)));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [2:0]        chan_sel,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              res_valid,
  output logic [2:0]        res_chan,
  output logic [11:0]       res_data
);
  logic             rise_evt;
  logic             fall_evt;
  logic             busy;
  logic [CNT_W-1:0] edge_cnt;
  logic [CH_W:0]    nch;

  sck_gen #(.HALF_CYC(HALF_CYC)) u_sck (
    .clk(clk), .rst_n(rst_n), .sck_o(sck_o),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt),
    .start_req(start_req), .chan_sel(chan_sel),
    .conv_o(conv_o), .busy(busy), .edge_cnt(edge_cnt), .nch(nch)
  );

  word_capture u_cap (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .busy(busy),
    .edge_cnt(edge_cnt), .sdo_i(sdo_i),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!conv_o && !sck_o && !res_valid));
endmodule

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [2:0]  chan_sel = 3'd0;
  logic        sdo_i = 1'b1;
  logic        conv_o, sck_o, res_valid;
  logic [2:0]  res_chan;
  logic [11:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];
  int words[6];
  int model_n = 1;
  int conv_rises = 0;
  int rise_t_prev = 0;
  int rise_t_last = 0;
  int got = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_frame_reader #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .chan_sel(chan_sel),
    .sdo_i(sdo_i), .conv_o(conv_o), .sck_o(sck_o), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // converter model: output changes just after each serial rising edge
  initial begin
    int m;
    bit act;
    m = 0;
    act = 1'b0;
    forever begin
      @(posedge sck_o);
      #1;
      if (conv_o) begin
        m = 0;
        act = 1'b1;
      end else if (act) begin
        m++;
        if (m >= 16 * model_n) act = 1'b0;
      end
      if (act && m >= 3 && ((m - 3) % 16) < 12)
        sdo_i = words[(m - 3) / 16][11 - ((m - 3) % 16)];
      else
        sdo_i = 1'b1; // don't-care and idle bits forced high (R6)
    end
  end

  // monitor: scoreboard pops, conv width, strobe width
  initial begin
    bit prev_v;
    bit prev_c;
    int wid;
    prev_v = 1'b0;
    prev_c = 1'b0;
    wid = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (conv_o) wid++;
        if (conv_o && !prev_c) begin
          conv_rises++;
          rise_t_prev = rise_t_last;
          rise_t_last = cyc;
        end
        if (!conv_o && prev_c) begin
          chk(wid == 2 * HALF, "R2 conv width", wid, 2 * HALF);
          wid = 0;
        end
        if (res_valid) begin
          got++;
          chk(!prev_v, "R7 strobe single cycle", int'(prev_v), 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R7 unexpected result", int'({res_chan, res_data}), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            chk({res_chan, res_data} == 15'(e), "R5 R6 R7 word/chan",
                int'({res_chan, res_data}), e);
          end
        end
        prev_v = res_valid;
        prev_c = conv_o;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  function automatic int pat(input int seed, input int s);
    if (seed == 100) return (s % 2) ? 0 : 'hFFF;
    return (seed * 1237 + s * 'h2B9 + 'h3C) & 'hFFF;
  endfunction

  function automatic int nch_of(input int sel);
    return (sel >= 5) ? 6 : sel + 1;
  endfunction

  task automatic load_frame(input int sel, input int seed);
    int n;
    n = nch_of(sel);
    for (int s = 0; s < n; s++) begin
      words[s] = pat(seed, s);
      exp_q.push_back((s << 12) | words[s]);
    end
    model_n = n;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int sel, input int seed);
    int n0;
    load_frame(sel, seed);
    got = 0;
    chan_sel = 3'(sel);
    start_req = 1'b1;
    @(posedge conv_o);
    #1;
    start_req = 1'b0;
    chan_sel = 3'(sel + 3); // R4: change after capture must not matter
    n0 = nch_of(sel);
    drain();
    chk(got == n0, "R4 result count", got, n0);
  endtask

  initial begin
    int hi;
    int lo;
    int rises0;
    repeat (4) @(negedge clk);
    // R9
    chk(!conv_o && !sck_o && !res_valid, "R9 reset state",
        int'({conv_o, sck_o, res_valid}), 0);
    rst_n = 1'b1;

    // R1 serial clock phases
    @(posedge sck_o);
    hi = 0;
    while (sck_o) begin @(posedge clk); #1; hi++; end
    lo = 0;
    while (!sck_o) begin @(posedge clk); #1; lo++; end
    chk(hi == HALF, "R1 high phase", hi, HALF);
    chk(lo == HALF, "R1 low phase", lo, HALF);

    // R4 R5 every select code, plus extreme patterns
    for (int sel = 0; sel < 8; sel++) run_frame(sel, sel + 7);
    run_frame(5, 100);
    run_frame(7, 100);
    run_frame(2, 0);

    // R3 start pulse in mid-frame ignored
    rises0 = conv_rises;
    load_frame(2, 55);
    chan_sel = 3'd2;
    start_req = 1'b1;
    @(posedge conv_o);
    #1;
    start_req = 1'b0;
    repeat (60) @(posedge clk);
    #1;
    start_req = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    start_req = 1'b0;
    drain();
    repeat (40) @(posedge clk);
    chk(conv_rises == rises0 + 1, "R3 mid-frame start ignored", conv_rises, rises0 + 1);

    // R8 back-to-back frames with start held
    load_frame(1, 77);
    for (int s = 0; s < 2; s++) exp_q.push_back((s << 12) | words[s]);
    chan_sel = 3'd1;
    start_req = 1'b1;
    @(posedge conv_o);
    @(posedge conv_o);
    #1;
    start_req = 1'b0;
    drain();
    chk(rise_t_last - rise_t_prev == (16 * 2 + 1) * 2 * HALF, "R8 frame spacing",
        rise_t_last - rise_t_prev, (16 * 2 + 1) * 2 * HALF);

    finish_run();
  end
endmodule